// File: doc/BRIEF.md
# Three-Row Shifting Line Buffer

This block keeps a sliding window of three consecutive image rows for a 3x3 convolution array. The rows live in three dual-port row memories linked in a chain: an entry slot that takes the newest row, a middle slot, and an oldest slot. A new row is written pixel by pixel into the entry slot. On a row-advance command the chain shifts one step, column by column, over dedicated links between the memories. The oldest row is dropped, the middle row becomes the oldest, and the entry row becomes the middle row. The entry slot is then free for the next row.

Each memory has two ports. Exactly one of them carries the shift traffic, and the two ports trade this role after every advance. The other port always serves the compute array, so all three rows of any column can be read every cycle, including while a shift runs. A read returns the three vertically aligned pixels of one column one cycle after the request, with a valid flag that is high only when all three slots hold complete rows.

Top module: `line3_shift_buf`

## Requirements
- R1: After reset `shift_busy` is 0, all three slots are empty, and a read request returns `rd_valid` = 0.
- R2: While no shift runs, each cycle with `wr_valid` = 1 writes `wr_pix` into the entry slot at the next column, starting at column 0. The W-th write marks the entry slot full and the column counter wraps to 0.
- R3: An accepted advance raises `shift_busy` for exactly W+2 cycles. At its end the old entry row is in the middle slot and the old middle row is in the oldest slot. The old oldest row is gone and the entry slot is marked empty.
- R4: A read with `rd_en` = 1 and column `rd_col` returns on the next cycle `win_old`, `win_mid` and `win_new`, the pixels of that column in the oldest, middle and entry slots. `rd_valid` is 1 only if `rd_en` was 1 and all three slots were full in the request cycle.
- R5: The port carrying the shift swaps between the two ports of every memory at the end of each advance and does not change during a shift. Reads keep working during a shift, and a column the shift has not yet reached returns the pre-shift pixels.
- R6: An advance request that arrives while a shift runs is held and starts a shift one idle cycle after the current one ends. Several such requests during one shift produce only one further shift.
- R7: Writes presented while `shift_busy` = 1 are ignored, and the column counter restarts at 0 after each shift.
- R8: Rows r, r+1, r+2 are written with an advance after each of the first two rows. For any N, after N further advances, each followed by writing the next row, the window holds rows N, N+1, N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | New-row pixel strobe |
| wr_pix | input | 8 | New-row pixel |
| adv_req | input | 1 | Row-advance command |
| shift_busy | output | 1 | A shift is in progress |
| rd_en | input | 1 | Column read request |
| rd_col | input | 6 | Column to read (below W) |
| rd_valid | output | 1 | Window pixels are valid |
| win_old | output | 8 | Pixel from the oldest row |
| win_mid | output | 8 | Pixel from the middle row |
| win_new | output | 8 | Pixel from the newest row |

## Verification
The window is filled from empty with a reference image whose pixel value depends on both row and column. It is then advanced several times, and every column is compared against the expected three rows. A swapped or stale row therefore shows up in every column, and a column skew shows up as a neighbour's value. Reads are issued at the last column while a shift runs, on two successive advances, so both port assignments must serve the compute side without returning data the shift has not yet reached. Junk writes during a shift and repeated advance requests during a shift are used to tell ignored or coalesced input apart from input that would offset the column counter or add a spurious shift.

// File: rtl/line3_shift_buf_pkg.sv
package line3_shift_buf_pkg;
    localparam int PIX_W   = 8;
    localparam int COL_AW  = 6;
    localparam int N_SLOTS = 3;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [COL_AW-1:0] addr;
        logic [PIX_W-1:0]  wd;
    } port_req_t;

    localparam port_req_t PORT_IDLE = '{en: 1'b0, we: 1'b0, addr: '0, wd: '0};

    function automatic port_req_t mk_req(input logic en, input logic we,
                                         input logic [COL_AW-1:0] addr,
                                         input logic [PIX_W-1:0] wd);
        port_req_t r;
        r.en   = en;
        r.we   = we & en;
        r.addr = addr;
        r.wd   = wd;
        return r;
    endfunction
endpackage

// File: rtl/line3_row_ram.sv
module line3_row_ram
    import line3_shift_buf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  port_req_t        req_a,
    input  port_req_t        req_b,
    output logic [PIX_W-1:0] rd_a,
    output logic [PIX_W-1:0] rd_b
);
    localparam int AW = $clog2(DEPTH);

    logic [PIX_W-1:0] mem [DEPTH];

    // Read-first on both ports: a write op also returns the old contents.
    always_ff @(posedge clk) begin
        if (req_a.en) begin
            rd_a <= mem[req_a.addr[AW-1:0]];
        end
        if (req_b.en) begin
            rd_b <= mem[req_b.addr[AW-1:0]];
        end
        if (req_a.we) begin
            mem[req_a.addr[AW-1:0]] <= req_a.wd;
        end
        if (req_b.we) begin
            mem[req_b.addr[AW-1:0]] <= req_b.wd;
        end
    end
endmodule

// File: rtl/line3_shift_ctrl.sv
module line3_shift_ctrl #(
    parameter int ROW_W = 16,
    localparam int CW   = $clog2(ROW_W + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_req,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic          pending,
    output logic          port_sel,
    output logic          done
);
    localparam logic [CW-1:0] LAST = CW'(ROW_W + 1);

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            pending  <= 1'b0;
            port_sel <= 1'b0;
        end else if (busy) begin
            if (adv_req) begin
                pending <= 1'b1;
            end
            if (cnt == LAST) begin
                busy     <= 1'b0;
                port_sel <= ~port_sel;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (adv_req || pending) begin
            busy    <= 1'b1;
            cnt     <= '0;
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/line3_shift_buf.sv
module line3_shift_buf
    import line3_shift_buf_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [PIX_W-1:0]  wr_pix,
    input  logic              adv_req,
    output logic              shift_busy,
    input  logic              rd_en,
    input  logic [COL_AW-1:0] rd_col,
    output logic              rd_valid,
    output logic [PIX_W-1:0]  win_old,
    output logic [PIX_W-1:0]  win_mid,
    output logic [PIX_W-1:0]  win_new
);
    localparam int CW = $clog2(ROW_W + 2);
    localparam logic [COL_AW-1:0] COL_LAST = COL_AW'(ROW_W - 1);

    logic          busy, pending, port_sel, done;
    logic [CW-1:0] cnt;
    logic [COL_AW-1:0] wcol;
    logic [N_SLOTS-1:0] slot_full;
    logic          cp_sel_q;

    port_req_t        sh_req [N_SLOTS];
    port_req_t        ram_a  [N_SLOTS];
    port_req_t        ram_b  [N_SLOTS];
    port_req_t        cp_req;
    logic [PIX_W-1:0] out_a  [N_SLOTS];
    logic [PIX_W-1:0] out_b  [N_SLOTS];
    logic [PIX_W-1:0] sh_rd  [N_SLOTS];
    logic [PIX_W-1:0] cp_rd  [N_SLOTS];

    line3_shift_ctrl #(.ROW_W(ROW_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .adv_req  (adv_req),
        .busy     (busy),
        .cnt      (cnt),
        .pending  (pending),
        .port_sel (port_sel),
        .done     (done)
    );

    assign shift_busy = busy;

    // Skewed chain: slot k handles column c at shift step c+k.
    always_comb begin
        cp_req = mk_req(rd_en, 1'b0, rd_col, '0);
        if (busy) begin
            sh_req[0] = mk_req(cnt < CW'(ROW_W), 1'b0, COL_AW'(cnt), '0);
            sh_req[1] = mk_req((cnt >= CW'(1)) && (cnt <= CW'(ROW_W)), 1'b1,
                               COL_AW'(cnt - CW'(1)), sh_rd[0]);
            sh_req[2] = mk_req((cnt >= CW'(2)) && (cnt <= CW'(ROW_W + 1)), 1'b1,
                               COL_AW'(cnt - CW'(2)), sh_rd[1]);
        end else begin
            sh_req[0] = mk_req(wr_valid, 1'b1, wcol, wr_pix);
            sh_req[1] = PORT_IDLE;
            sh_req[2] = PORT_IDLE;
        end
    end

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        assign ram_a[k] = port_sel ? cp_req : sh_req[k];
        assign ram_b[k] = port_sel ? sh_req[k] : cp_req;
        assign sh_rd[k] = port_sel ? out_b[k] : out_a[k];
        assign cp_rd[k] = cp_sel_q ? out_a[k] : out_b[k];

        line3_row_ram #(.DEPTH(ROW_W)) u_ram (
            .clk   (clk),
            .req_a (ram_a[k]),
            .req_b (ram_b[k]),
            .rd_a  (out_a[k]),
            .rd_b  (out_b[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcol      <= '0;
            slot_full <= '0;
            rd_valid  <= 1'b0;
            cp_sel_q  <= 1'b0;
        end else begin
            cp_sel_q <= port_sel;
            rd_valid <= rd_en && (&slot_full);
            if (busy) begin
                wcol <= '0;
                if (done) begin
                    slot_full <= {slot_full[1], slot_full[0], 1'b0};
                end
            end else if (wr_valid) begin
                if (wcol == COL_LAST) begin
                    wcol         <= '0;
                    slot_full[0] <= 1'b1;
                end else begin
                    wcol <= wcol + 1'b1;
                end
            end
        end
    end

    assign win_old = cp_rd[2];
    assign win_mid = cp_rd[1];
    assign win_new = cp_rd[0];
endmodule

// File: rtl/line3_shift_buf_chk.sv
module line3_shift_buf_chk #(
    parameter int ROW_W = 16
) (
    input logic clk,
    input logic rst,
    input logic adv_req,
    input logic shift_busy,
    input logic pending,
    input logic port_sel,
    input logic rd_en,
    input logic rd_valid
);
    logic [7:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len <= '0;
        end else begin
            busy_len <= shift_busy ? busy_len + 1'b1 : 8'd0;
        end
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_busy) |-> (busy_len == 8'(ROW_W + 2)));

    assert_read_origin_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

    assert_port_swap_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_busy) |-> (port_sel != $past(port_sel)));

    assert_port_hold_R5: assert property (@(posedge clk) disable iff (rst)
        shift_busy |-> $stable(port_sel));

    assert_adv_held_R6: assert property (@(posedge clk) disable iff (rst)
        (shift_busy && adv_req) |=> pending);

    assert_adv_start_R6: assert property (@(posedge clk) disable iff (rst)
        (!shift_busy && pending) |=> shift_busy);
endmodule

bind line3_shift_buf line3_shift_buf_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adv_req    (adv_req),
    .shift_busy (shift_busy),
    .pending    (pending),
    .port_sel   (port_sel),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid)
);

// File: tb/sim_line3_shift_buf.sv
module sim_line3_shift_buf;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_pix = '0;
    logic       adv_req = 1'b0;
    logic       shift_busy;
    logic       rd_en = 1'b0;
    logic [5:0] rd_col = '0;
    logic       rd_valid;
    logic [7:0] win_old, win_mid, win_new;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line3_shift_buf #(.ROW_W(W)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_pix(wr_pix),
        .adv_req(adv_req), .shift_busy(shift_busy), .rd_en(rd_en),
        .rd_col(rd_col), .rd_valid(rd_valid), .win_old(win_old),
        .win_mid(win_mid), .win_new(win_new)
    );

    function automatic logic [7:0] pix(input int r, input int c);
        return 8'((r * 53) + (c * 7) + 3);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_row(input int r);
        for (int c = 0; c < W; c++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_pix   = pix(r, c);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic read_col(input int c);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_col = 6'(c);
        @(negedge clk);
        rd_en  = 1'b0;
    endtask

    task automatic advance(input string req);
        int n;
        @(negedge clk);
        adv_req = 1'b1;
        @(negedge clk);
        adv_req = 1'b0;
        n = 0;
        while (shift_busy) begin
            n++;
            @(negedge clk);
        end
        check({req, " busy length"}, n, W + 2);
    endtask

    task automatic check_window(input int base, input string req);
        for (int c = 0; c < W; c++) begin
            read_col(c);
            check({req, " valid"}, int'(rd_valid), 1);
            check({req, " old row"}, int'(win_old), int'(pix(base, c)));
            check({req, " mid row"}, int'(win_mid), int'(pix(base + 1, c)));
            check({req, " new row"}, int'(win_new), int'(pix(base + 2, c)));
        end
    endtask

    task automatic t_reset();
        check("R1 busy after reset", int'(shift_busy), 0);
        read_col(0);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
    endtask

    task automatic t_fill();
        load_row(0);
        advance("R3 fill");
        load_row(1);
        advance("R3 fill");
        read_col(0);
        check("R4 two rows only", int'(rd_valid), 0);
        load_row(2);
        check_window(0, "R2 R8 first window");
    endtask

    task automatic t_advance();
        for (int n = 1; n <= 2; n++) begin
            advance("R3 advance");
            read_col(3);
            check("R3 entry slot empty", int'(rd_valid), 0);
            load_row(n + 2);
            check_window(n, "R8 window");
        end
    endtask

    task automatic t_read_during(input int base);
        @(negedge clk);
        adv_req = 1'b1;
        @(negedge clk);
        adv_req = 1'b0;
        rd_en   = 1'b1;
        rd_col  = 6'(W - 1);
        @(negedge clk);
        rd_en   = 1'b0;
        check("R5 busy during read", int'(shift_busy), 1);
        check("R5 valid during shift", int'(rd_valid), 1);
        check("R5 old during shift", int'(win_old), int'(pix(base, W - 1)));
        check("R5 mid during shift", int'(win_mid), int'(pix(base + 1, W - 1)));
        check("R5 new during shift", int'(win_new), int'(pix(base + 2, W - 1)));
        while (shift_busy) @(negedge clk);
        load_row(base + 3);
        check_window(base + 1, "R5 window after shift");
    endtask

    task automatic t_ignore();
        @(negedge clk);
        adv_req = 1'b1;
        @(negedge clk);
        adv_req  = 1'b0;
        for (int i = 0; i < 5; i++) begin
            wr_valid = 1'b1;
            wr_pix   = 8'hEE;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        while (shift_busy) @(negedge clk);
        load_row(7);
        check_window(5, "R7 writes ignored during shift");
    endtask

    task automatic t_hold();
        int n;
        @(negedge clk);
        adv_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        adv_req = 1'b0;
        check("R6 first shift running", int'(shift_busy), 1);
        while (shift_busy) @(negedge clk);
        @(negedge clk);
        check("R6 held shift starts", int'(shift_busy), 1);
        n = 0;
        while (shift_busy) begin
            n++;
            @(negedge clk);
        end
        check("R6 held shift length", n, W + 2);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R6 requests coalesced", int'(shift_busy), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired, R3 shift or bench never completed");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_advance();
        t_read_during(2);
        t_read_during(3);
        t_ignore();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule